// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block sits between an on-chip requester and an external asynchronous static RAM with a 17-bit address, an 8-bit shared data bus and four control strobes. These are a low-true select, a high-true select, a low-true read-drive enable and a low-true write strobe. The requester hands over one word per transaction on a valid/ready request channel. The block turns each transaction into a pin sequence built from registered outputs. Every strobe is held for a whole number of clock cycles, and those counts are parameters. Each count is checked at elaboration against the memory's nanosecond limits for the chosen clock period.

A read selects the chip with the read-drive enable low for a fixed number of cycles. The data bus is sampled on the last edge of that window, and the byte comes back with a one-cycle response pulse. A write selects the chip and pulls the write strobe low, while the read-drive enable stays high. After a turnaround delay, the block switches on its own bus driver. The strobe, the driver and the select are all released on one edge, and a one-cycle completion pulse follows.

Back-pressure is simple. The request channel accepts a transaction only on an edge where both valid and ready are high. Ready is high only while the block is idle. A requester that sees ready low must hold valid and its fields steady. There is no back-pressure on the responses. The read-response and write-completion pulses must be taken in the cycle they appear.

Top module: `sram_bus_ctrl`

## Requirements
- R1: While reset is asserted and afterwards until the first request is accepted, both selects are inactive (low-true select 1, high-true select 0), the read-drive enable and the write strobe are high, the bus driver is off, ready is 1, and both response pulses are 0.
- R2: A request is taken only on an edge with valid and ready both high. Ready is 0 in every cycle in which the chip is selected. Each accepted request produces exactly one chip access.
- R3: A read holds both selects active, the write strobe high and the read-drive enable low for exactly RD_CYC cycles, with the address equal to the request address.
- R4: The read byte is the value on the data-in pins at the final edge of the read window. It is presented with a one-cycle rsp_valid pulse that starts on that same edge.
- R5: A write holds the write strobe low for exactly WP_CYC cycles, and the read-drive enable stays high throughout the write.
- R6: The bus driver turns on only after the write strobe has been low for TA_CYC cycles, and it turns off on the edge where the strobe rises. It is on for exactly WP_CYC-TA_CYC cycles and drives the request data. It is never on while the memory is driving the bus.
- R7: A write reports completion with a one-cycle wr_done pulse that starts on the edge where the write strobe rises.
- R8: The two selects always change together, with the low-true select equal to the inverse of the high-true select. The address does not change while the chip is selected.
- R9: Elaboration fails unless RD_CYC*CLK_NS is at least 25 ns. It also fails unless WP_CYC covers 12 ns, covers 20 ns, and with one idle cycle covers 25 ns; unless SU_CYC and TA_CYC each cover 10 ns; and unless WP_CYC is at least TA_CYC+SU_CYC.
- R10: Between two accesses the chip is deselected for at least one full cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, low-true |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle pulse: read byte on rsp_rdata |
| rsp_rdata | output | 8 | Captured read byte |
| wr_done | output | 1 | One-cycle pulse: write finished |
| mem_addr | output | 17 | Address pins |
| mem_sel_n | output | 1 | Low-true chip select |
| mem_sel | output | 1 | High-true chip select |
| mem_rd_n | output | 1 | Low-true read-drive enable |
| mem_wr_n | output | 1 | Low-true write strobe |
| mem_dq_out | output | 8 | Byte the block drives onto the data bus |
| mem_dq_oe | output | 1 | Enable of the block's bus driver |
| mem_dq_in | input | 8 | Data bus as seen at the pins |

## Verification
The bench builds the block with a 4 ns clock. Every count is set to the smallest value the elaboration check allows: RD_CYC=7, WP_CYC=6, TA_CYC=3 and SU_CYC=3. Because each count sits at its minimum, the bus model in the bench runs right at its limits. If any window is one cycle shorter, the model returns a poisoned read byte, sees a short write strobe or sees data set up too late, or it detects bus contention. These settings also let the bench reach the address extremes 0 and 0x1FFFF, overwrites of a single word, back-to-back accesses whose requests were stalled by ready, and reads of words that were never written.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } seq_state_e;
endpackage

// File: rtl/sram_seq.sv
module sram_seq
  import sram_ctrl_pkg::*;
#(
  parameter int RD_CYC = 7,
  parameter int WP_CYC = 6,
  parameter int TA_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_write,
  output logic req_ready,
  output logic start_rd,
  output logic start_wr,
  output logic drv_on,
  output logic end_rd,
  output logic end_wr
);
  localparam int MAXC = (RD_CYC > WP_CYC) ? RD_CYC : WP_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  seq_state_e st;
  logic [CW-1:0] cnt;

  assign req_ready = (st == ST_IDLE);
  assign start_rd  = req_ready && req_valid && !req_write;
  assign start_wr  = req_ready && req_valid && req_write;
  assign end_rd    = (st == ST_READ)  && (cnt == CW'(RD_CYC - 1));
  assign end_wr    = (st == ST_WRITE) && (cnt == CW'(WP_CYC - 1));
  assign drv_on    = (st == ST_WRITE) && (cnt == CW'(TA_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          cnt <= '0;
          if (start_rd) st <= ST_READ;
          else if (start_wr) st <= ST_WRITE;
        end
        ST_READ: begin
          cnt <= end_rd ? '0 : cnt + 1'b1;
          if (end_rd) st <= ST_IDLE;
        end
        ST_WRITE: begin
          cnt <= end_wr ? '0 : cnt + 1'b1;
          if (end_wr) st <= ST_IDLE;
        end
        default: begin
          st  <= ST_IDLE;
          cnt <= '0;
        end
      endcase
    end
  end

  // R2: no new access can start while one is running
  a_r2_no_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_IDLE) |-> !(start_rd || start_wr));
endmodule

// File: rtl/sram_pins.sv
module sram_pins #(
  parameter int AW     = 17,
  parameter int DW     = 8,
  parameter int WP_CYC = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_rd,
  input  logic          start_wr,
  input  logic          drv_on,
  input  logic          end_acc,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] wdata_in,
  output logic [AW-1:0] mem_addr,
  output logic          mem_sel_n,
  output logic          mem_sel,
  output logic          mem_rd_n,
  output logic          mem_wr_n,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe
);
  localparam int LW = $clog2(WP_CYC + 2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr   <= '0;
      mem_dq_out <= '0;
      mem_sel_n  <= 1'b1;
      mem_sel    <= 1'b0;
      mem_rd_n   <= 1'b1;
      mem_wr_n   <= 1'b1;
      mem_dq_oe  <= 1'b0;
    end else begin
      if (start_rd || start_wr) begin
        mem_addr  <= addr_in;
        mem_sel_n <= 1'b0;
        mem_sel   <= 1'b1;
      end
      if (start_wr) mem_dq_out <= wdata_in;
      if (start_rd) mem_rd_n <= 1'b0;
      if (start_wr) mem_wr_n <= 1'b0;
      if (drv_on)   mem_dq_oe <= 1'b1;
      if (end_acc) begin
        mem_sel_n <= 1'b1;
        mem_sel   <= 1'b0;
        mem_rd_n  <= 1'b1;
        mem_wr_n  <= 1'b1;
        mem_dq_oe <= 1'b0;
      end
    end
  end

  // cycle counter for the write-strobe width check
  logic [LW-1:0] wlo_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wlo_cnt <= '0;
    else if (!mem_wr_n) wlo_cnt <= wlo_cnt + 1'b1;
    else wlo_cnt <= '0;
  end

  // R5: strobe low exactly WP_CYC cycles
  a_r5_wr_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_wr_n) |-> (wlo_cnt == LW'(WP_CYC)));
  // R5: read drive never enabled during a write
  a_r5_rd_high_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_wr_n |-> mem_rd_n);
  // R6: own driver only inside the write strobe
  a_r6_drv_in_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> !mem_wr_n);
  // R8: selects move together, address held while selected
  a_r8_select_pair: assert property (@(posedge clk) disable iff (!rst_n)
    mem_sel_n == !mem_sel);
  a_r8_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_sel_n |=> (mem_sel_n || $stable(mem_addr)));
endmodule

// File: rtl/sram_rsp.sv
module sram_rsp #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          end_rd,
  input  logic          end_wr,
  input  logic [DW-1:0] dq_in,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          wr_done
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      wr_done   <= 1'b0;
    end else begin
      rsp_valid <= end_rd;
      wr_done   <= end_wr;
      if (end_rd) rsp_rdata <= dq_in;
    end
  end

  // R4, R7: one-cycle pulses, never both at once
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |=> !wr_done);
  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_valid && wr_done));
endmodule

// File: rtl/sram_bus_ctrl.sv
module sram_bus_ctrl #(
  parameter int AW       = 17,
  parameter int DW       = 8,
  parameter int CLK_NS   = 4,
  parameter int RD_CYC   = 7,
  parameter int WP_CYC   = 6,
  parameter int SU_CYC   = 3,
  parameter int TA_CYC   = 3,
  parameter int T_CYC_NS = 25,
  parameter int T_WP_NS  = 12,
  parameter int T_AW_NS  = 20,
  parameter int T_SU_NS  = 10,
  parameter int T_TA_NS  = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          wr_done,
  output logic [AW-1:0] mem_addr,
  output logic          mem_sel_n,
  output logic          mem_sel,
  output logic          mem_rd_n,
  output logic          mem_wr_n,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in
);
  localparam int MIN_CYC = (T_CYC_NS + CLK_NS - 1) / CLK_NS;
  localparam int MIN_WP  = (T_WP_NS  + CLK_NS - 1) / CLK_NS;
  localparam int MIN_AW  = (T_AW_NS  + CLK_NS - 1) / CLK_NS;
  localparam int MIN_SU  = (T_SU_NS  + CLK_NS - 1) / CLK_NS;
  localparam int MIN_TA  = (T_TA_NS  + CLK_NS - 1) / CLK_NS;

  // R9: elaboration-time timing check
  if (RD_CYC < MIN_CYC || WP_CYC < MIN_WP || WP_CYC < MIN_AW ||
      WP_CYC + 1 < MIN_CYC || SU_CYC < MIN_SU || TA_CYC < MIN_TA ||
      WP_CYC < TA_CYC + SU_CYC) begin : g_r9_bad_timing
    $error("sram_bus_ctrl: cycle counts too short for CLK_NS=%0d", CLK_NS);
  end

  logic start_rd, start_wr, drv_on, end_rd, end_wr;

  sram_seq #(.RD_CYC(RD_CYC), .WP_CYC(WP_CYC), .TA_CYC(TA_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_ready(req_ready), .start_rd(start_rd), .start_wr(start_wr),
    .drv_on(drv_on), .end_rd(end_rd), .end_wr(end_wr)
  );

  sram_pins #(.AW(AW), .DW(DW), .WP_CYC(WP_CYC)) u_pins (
    .clk(clk), .rst_n(rst_n), .start_rd(start_rd), .start_wr(start_wr),
    .drv_on(drv_on), .end_acc(end_rd || end_wr), .addr_in(req_addr),
    .wdata_in(req_wdata), .mem_addr(mem_addr), .mem_sel_n(mem_sel_n),
    .mem_sel(mem_sel), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe)
  );

  sram_rsp #(.DW(DW)) u_rsp (
    .clk(clk), .rst_n(rst_n), .end_rd(end_rd), .end_wr(end_wr),
    .dq_in(mem_dq_in), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .wr_done(wr_done)
  );

  // R2: ready low whenever the chip is selected
  a_r2_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_sel_n |-> !req_ready);
  // R3: read drive only with write strobe high and chip selected
  a_r3_read_shape: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_rd_n |-> (mem_wr_n && !mem_sel_n));
  // R4: a response follows a cycle with read drive low
  a_r4_rsp_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(!mem_rd_n));
endmodule

// File: tb/sram_bus_ctrl_test.sv
module sram_bus_ctrl_test;
  localparam int AW = 17, DW = 8, TCK = 4;
  localparam int RD = 7, WP = 6, SU = 3, TA = 3;
  localparam int LIM_CYC = (25 + TCK - 1) / TCK;
  localparam int LIM_WP  = (12 + TCK - 1) / TCK;
  localparam int LIM_SU  = (10 + TCK - 1) / TCK;
  localparam int LIM_OFF = (10 + TCK - 1) / TCK;

  typedef struct { bit is_wr; logic [DW-1:0] data; logic [AW-1:0] addr; } exp_t;

  logic clk = 1'b0;
  always #2 clk = ~clk;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, wr_done;
  logic [DW-1:0] rsp_rdata, mem_dq_out;
  logic [AW-1:0] mem_addr;
  logic mem_sel_n, mem_sel, mem_rd_n, mem_wr_n, mem_dq_oe;
  logic [DW-1:0] mem_dq_in = '0;

  sram_bus_ctrl #(.AW(AW), .DW(DW), .CLK_NS(TCK), .RD_CYC(RD), .WP_CYC(WP),
                  .SU_CYC(SU), .TA_CYC(TA)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .wr_done(wr_done),
    .mem_addr(mem_addr), .mem_sel_n(mem_sel_n), .mem_sel(mem_sel),
    .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  int checks = 0, fails = 0, sends = 0, accesses = 0;
  bit done = 1'b0;
  exp_t q[$];
  logic [DW-1:0] shadow [int];
  logic [DW-1:0] mmem [int];

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] mlook(logic [AW-1:0] a);
    return mmem.exists(int'(a)) ? mmem[int'(a)] : '0;
  endfunction

  // memory model, sampled away from the active edge
  int we_lo = 0, dq_cnt = 0, rd_cnt = 0, idle_cnt = 0;
  bit prev_wr_n = 1'b1, prev_sel_n = 1'b1, prev_oe = 1'b0, rd_act = 1'b0;
  logic [DW-1:0] wlatch = '0;
  logic [AW-1:0] sel_addr = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_sel_n != !mem_sel) chk(0, "R8", "select pair", mem_sel_n, !mem_sel);
      if (!mem_sel_n && !prev_sel_n && mem_addr != sel_addr)
        chk(0, "R8", "address moved while selected", mem_addr, sel_addr);
      if (mem_dq_oe && !mem_sel_n && !mem_rd_n)
        chk(0, "R6", "bus contention", 1, 0);
      if (prev_sel_n && !mem_sel_n) begin
        accesses++;
        sel_addr = mem_addr;
        chk(idle_cnt >= 1, "R10", "idle gap", idle_cnt, 1);
        chk(!req_ready, "R2", "ready while selected", req_ready, 0);
      end
      idle_cnt = mem_sel_n ? idle_cnt + 1 : 0;
      // write side
      if (!mem_wr_n) begin
        we_lo++;
        if (!mem_rd_n) chk(0, "R5", "read drive low in write", 0, 1);
      end
      if (mem_dq_oe) begin
        if (!prev_oe) chk(we_lo - 1 >= LIM_OFF, "R6", "driver before turn-off", we_lo - 1, LIM_OFF);
        dq_cnt++;
        wlatch = mem_dq_out;
      end
      if (!prev_wr_n && mem_wr_n) begin
        mmem[int'(sel_addr)] = wlatch;
        chk(we_lo == WP, "R5", "strobe width", we_lo, WP);
        chk(we_lo >= LIM_WP, "R5", "strobe min", we_lo, LIM_WP);
        chk(dq_cnt == WP - TA, "R6", "driver cycles", dq_cnt, WP - TA);
        chk(dq_cnt >= LIM_SU, "R6", "data setup", dq_cnt, LIM_SU);
        chk(wr_done, "R7", "completion pulse on strobe rise", wr_done, 1);
        we_lo = 0; dq_cnt = 0;
      end
      // read side
      if (!mem_sel_n && !mem_rd_n && mem_wr_n) begin
        rd_act = 1'b1;
        rd_cnt++;
        mem_dq_in <= (rd_cnt >= LIM_CYC) ? mlook(mem_addr) : 8'hEE;
      end else begin
        if (rd_act) begin
          chk(rd_cnt == RD, "R3", "read window", rd_cnt, RD);
          chk(rsp_valid, "R4", "response on window end", rsp_valid, 1);
        end
        rd_act = 1'b0; rd_cnt = 0;
        mem_dq_in <= 8'h00;
      end
      prev_wr_n = mem_wr_n; prev_sel_n = mem_sel_n; prev_oe = mem_dq_oe;
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && (rsp_valid || wr_done)) begin
      if (q.size() == 0) chk(0, "R2", "response without request", 1, 0);
      else begin
        exp_t e;
        e = q.pop_front();
        if (rsp_valid) begin
          chk(!e.is_wr, "R4", "read pulse for write", 1, 0);
          chk(rsp_rdata == e.data, "R4", "read data", rsp_rdata, e.data);
        end else chk(e.is_wr, "R7", "write pulse for read", 1, 0);
      end
    end
  end

  task automatic send(bit w, logic [AW-1:0] a, logic [DW-1:0] d);
    exp_t e;
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    sends++;
    e.is_wr = w; e.addr = a;
    if (w) begin shadow[int'(a)] = d; e.data = d; end
    else e.data = shadow.exists(int'(a)) ? shadow[int'(a)] : '0;
    q.push_back(e);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    logic [AW-1:0] addrs [30];
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(mem_sel_n && !mem_sel && mem_rd_n && mem_wr_n && !mem_dq_oe, "R1", "pins in reset",
        {mem_sel_n, mem_sel, mem_rd_n, mem_wr_n, mem_dq_oe}, 5'b10110);
    chk(req_ready && !rsp_valid && !wr_done, "R1", "handshake in reset",
        {req_ready, rsp_valid, wr_done}, 3'b100);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(mem_sel_n && !mem_sel && mem_rd_n && mem_wr_n && !mem_dq_oe && req_ready, "R1",
        "idle after reset", {mem_sel_n, mem_sel, mem_rd_n, mem_wr_n, mem_dq_oe}, 5'b10110);
    // address extremes and overwrite
    send(1, 17'h00000, 8'h5A);
    send(1, 17'h1FFFF, 8'hA5);
    send(0, 17'h00000, 8'h00);
    send(0, 17'h1FFFF, 8'h00);
    send(1, 17'h00000, 8'h3C);
    send(0, 17'h00000, 8'h00);
    send(0, 17'h0ABCD, 8'h00);   // never written
    // random fill and readback
    for (int i = 0; i < 30; i++) begin
      addrs[i] = AW'($urandom);
      send(1, addrs[i], DW'($urandom));
    end
    for (int i = 0; i < 30; i++) send(0, addrs[i], 8'h00);
    repeat (RD + 4) @(negedge clk);
    chk(q.size() == 0, "R2", "outstanding responses", q.size(), 0);
    chk(accesses == sends, "R2", "one access per request", accesses, sends);
    chk(req_ready && mem_sel_n, "R2", "idle at end", req_ready, 1);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule